// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides where a digital PLL takes its output frequency word from. It has three modes. In free run the output is the local oscillator with no steering, so the offset word is zero. In locked mode the loop filter's word drives the output. In holdover the output comes from the averaged frequency history, or it stays frozen at the last output word when no usable history exists.

The block's inputs are:

- a manual/automatic select;
- a manual mode code;
- a forced-holdover request;
- one valid flag per reference;
- a lock-detect indication from the loop;
- a history-available flag;
- the loop and history frequency words.

Its outputs are all registered:

- the current mode;
- a locked status bit;
- a loss-of-lock flag;
- the chosen frequency source and the resulting frequency word;
- a holdover-duration counter that software may read.

Phase detection, filtering and the oscillator are outside this block. In automatic operation the controller enters locked mode whenever any reference is valid. It falls into holdover only when no reference is valid at all, and it never returns to free run by itself. A manual command takes effect on the next clock edge, as does every other mode change.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: The mode output uses codes 0 = free run, 1 = locked and 2 = holdover, and never shows 3. After reset: mode is 0, locked and loss-of-lock are 0, the source is 0, the frequency word is 0 and the hold timer is 0.
- R2: In free run the source code is 0 (oscillator) and the frequency word is 0. With auto_en=1 and force_hold=0, the mode moves from free run to locked on the next edge when any bit of ref_vld is 1.
- R3: The locked output is 0 on the edge that enters locked mode. It becomes 1 on the edge after lock_det is sampled high while in locked mode. It is 0 in every other mode.
- R4: Loss-of-lock rises when lock_det is sampled low while in locked mode with locked=1. It stays 1 while lock_det stays low and clears when lock_det returns or the mode leaves locked.
- R5: With auto_en=1 and force_hold=0, locked mode moves to holdover on the next edge only when ref_vld is all zero. While any reference is valid the mode stays locked. Automatic operation never returns to free run.
- R6: With auto_en=1 and force_hold=0, holdover moves to locked on the next edge when any reference becomes valid, with locked cleared on that edge.
- R7: In holdover with hist_avail=1, the source is 2 and the word equals hist_word. With hist_avail=0, the source is 3 and the word keeps its previous value.
- R8: In locked mode the source is 1 and the word equals loop_word, sampled on the same edge.
- R9: The hold timer reads 0 on the edge that enters holdover and rises by one on each further edge spent in holdover. It keeps its value after holdover is left, until the next entry.
- R10: The hold timer saturates at 2^TW-1 and does not wrap.
- R11: With auto_en=0, man_mode 0, 1 or 2 selects that mode on the next edge, and code 3 keeps the current mode. With auto_en=1, force_hold=1 forces holdover and takes priority over every automatic transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_en | input | 1 | 1 = automatic mode control, 0 = manual |
| man_mode | input | 2 | Manual mode code (3 = keep current) |
| force_hold | input | 1 | Forces holdover in automatic operation |
| ref_vld | input | NREF | Per-reference valid flags |
| lock_det | input | 1 | Lock indication from the loop |
| hist_avail | input | 1 | Usable holdover history exists |
| loop_word | input | FW | Loop filter frequency word |
| hist_word | input | FW | Averaged history frequency word |
| mode | output | 2 | Current mode |
| locked | output | 1 | Lock achieved status |
| lol | output | 1 | Loss-of-lock flag |
| freq_src | output | 2 | Source: 0 osc, 1 loop, 2 history, 3 frozen |
| freq_word | output | FW | Selected output frequency word |
| hold_time | output | TW | Cycles spent in current/last holdover |

## Verification
The assertions check these properties on every cycle:

- the mode code is legal;
- locked and loss-of-lock appear only in locked mode;
- free run outputs a zero word;
- the frozen source keeps the word stable;
- the timer starts at zero on entry and holds at its maximum;
- automatic holdover entry happens once every reference is gone.

Only the bench's scenarios can show the full ordered behaviour:

- the delayed setting of locked after lock-detect;
- loss-of-lock recovery;
- return from holdover when a reference reappears;
- manual-code priority, including the ignored code 3;
- the timer value retained across an exit and restarted on re-entry.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_LOOP = 2'd1,
        SRC_HIST = 2'd2,
        SRC_LAST = 2'd3
    } src_e;
endpackage

// File: rtl/dmc_mode_next.sv
module dmc_mode_next
    import dmc_pkg::*;
(
    input  mode_e      mode_q,
    input  logic       auto_en,
    input  logic [1:0] man_mode,
    input  logic       force_hold,
    input  logic       any_ref,
    output mode_e      mode_d
);
    always_comb begin
        mode_d = mode_q;
        if (!auto_en) begin
            // manual code 3 is not a mode: keep the current one
            case (man_mode)
                2'd0:    mode_d = MODE_FREE;
                2'd1:    mode_d = MODE_LOCK;
                2'd2:    mode_d = MODE_HOLD;
                default: mode_d = mode_q;
            endcase
        end else if (force_hold) begin
            mode_d = MODE_HOLD;
        end else if (any_ref) begin
            mode_d = MODE_LOCK;
        end else if (mode_q != MODE_FREE) begin
            mode_d = MODE_HOLD;
        end
    end
endmodule

// File: rtl/dmc_freq_sel.sv
module dmc_freq_sel
    import dmc_pkg::*;
#(
    parameter int FW = 24
) (
    input  mode_e          mode_d,
    input  logic           hist_avail,
    input  logic [FW-1:0]  loop_word,
    input  logic [FW-1:0]  hist_word,
    input  logic [FW-1:0]  word_q,
    output src_e           src_d,
    output logic [FW-1:0]  word_d
);
    always_comb begin
        src_d  = SRC_OSC;
        word_d = '0;
        case (mode_d)
            MODE_LOCK: begin
                src_d  = SRC_LOOP;
                word_d = loop_word;
            end
            MODE_HOLD: begin
                if (hist_avail) begin
                    src_d  = SRC_HIST;
                    word_d = hist_word;
                end else begin
                    src_d  = SRC_LAST;
                    word_d = word_q;
                end
            end
            default: begin
                src_d  = SRC_OSC;
                word_d = '0;
            end
        endcase
    end
endmodule

// File: rtl/dmc_hold_timer.sv
module dmc_hold_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_q,
    input  logic          hold_d,
    output logic [TW-1:0] count
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (hold_d && !hold_q) begin
            count_d = '0;
        end else if (hold_d && hold_q && count_q != CNT_MAX) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dmc_pkg::*;
#(
    parameter int NREF = 4,
    parameter int FW   = 24,
    parameter int TW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            auto_en,
    input  logic [1:0]      man_mode,
    input  logic            force_hold,
    input  logic [NREF-1:0] ref_vld,
    input  logic            lock_det,
    input  logic            hist_avail,
    input  logic [FW-1:0]   loop_word,
    input  logic [FW-1:0]   hist_word,
    output logic [1:0]      mode,
    output logic            locked,
    output logic            lol,
    output logic [1:0]      freq_src,
    output logic [FW-1:0]   freq_word,
    output logic [TW-1:0]   hold_time
);
    typedef struct packed {
        mode_e         mode;
        logic          locked;
        logic          lol;
        src_e          src;
        logic [FW-1:0] word;
    } state_t;

    state_t st_d, st_q;
    mode_e  mode_nx;
    src_e   src_nx;
    logic [FW-1:0] word_nx;
    logic   stay_lock;

    dmc_mode_next u_next (
        .mode_q     (st_q.mode),
        .auto_en    (auto_en),
        .man_mode   (man_mode),
        .force_hold (force_hold),
        .any_ref    (|ref_vld),
        .mode_d     (mode_nx)
    );

    dmc_freq_sel #(.FW(FW)) u_sel (
        .mode_d     (mode_nx),
        .hist_avail (hist_avail),
        .loop_word  (loop_word),
        .hist_word  (hist_word),
        .word_q     (st_q.word),
        .src_d      (src_nx),
        .word_d     (word_nx)
    );

    dmc_hold_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_q (st_q.mode == MODE_HOLD),
        .hold_d (mode_nx == MODE_HOLD),
        .count  (hold_time)
    );

    always_comb begin
        stay_lock   = (st_q.mode == MODE_LOCK) && (mode_nx == MODE_LOCK);
        st_d        = st_q;
        st_d.mode   = mode_nx;
        st_d.src    = src_nx;
        st_d.word   = word_nx;
        // status sets only after lock seen while already locked
        st_d.locked = stay_lock && lock_det;
        st_d.lol    = stay_lock && !lock_det && (st_q.locked || st_q.lol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_FREE, locked: 1'b0, lol: 1'b0,
                      src: SRC_OSC, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode      = st_q.mode;
    assign locked    = st_q.locked;
    assign lol       = st_q.lol;
    assign freq_src  = st_q.src;
    assign freq_word = st_q.word;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int NREF = 4,
    parameter int FW   = 24,
    parameter int TW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            auto_en,
    input logic            force_hold,
    input logic [NREF-1:0] ref_vld,
    input logic [1:0]      mode,
    input logic            locked,
    input logic            lol,
    input logic [1:0]      freq_src,
    input logic [FW-1:0]   freq_word,
    input logic [TW-1:0]   hold_time
);
    localparam logic [TW-1:0] TMAX = '1;

    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

    a_r2_free_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (freq_src == 2'd0 && freq_word == '0));

    a_r3_locked_only_lock: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (mode == 2'd1));

    a_r4_lol_only_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lol |-> (mode == 2'd1 && !locked));

    a_r5_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !force_hold && ref_vld == '0 && mode == 2'd1)
        |=> (mode == 2'd2));

    a_r7_frozen_word: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_src == 2'd3) |-> $stable(freq_word));

    a_r9_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd2) |=> (mode != 2'd2 || hold_time == '0));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && hold_time == TMAX) |=> (hold_time == TMAX));
endmodule

bind dpll_mode_ctrl dmc_checker #(.NREF(NREF), .FW(FW), .TW(TW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .force_hold (force_hold),
    .ref_vld    (ref_vld),
    .mode       (mode),
    .locked     (locked),
    .lol        (lol),
    .freq_src   (freq_src),
    .freq_word  (freq_word),
    .hold_time  (hold_time)
);

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;
    localparam int NREF = 4;
    localparam int FW   = 24;
    localparam int TW   = 8;
    localparam int NV   = 17;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            auto_en;
    logic [1:0]      man_mode;
    logic            force_hold;
    logic [NREF-1:0] ref_vld;
    logic            lock_det;
    logic            hist_avail;
    logic [FW-1:0]   loop_word;
    logic [FW-1:0]   hist_word;
    logic [1:0]      mode;
    logic            locked;
    logic            lol;
    logic [1:0]      freq_src;
    logic [FW-1:0]   freq_word;
    logic [TW-1:0]   hold_time;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;   // 50 MHz

    dpll_mode_ctrl #(.NREF(NREF), .FW(FW), .TW(TW)) i_dpll_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .man_mode(man_mode),
        .force_hold(force_hold), .ref_vld(ref_vld), .lock_det(lock_det),
        .hist_avail(hist_avail), .loop_word(loop_word), .hist_word(hist_word),
        .mode(mode), .locked(locked), .lol(lol), .freq_src(freq_src),
        .freq_word(freq_word), .hold_time(hold_time)
    );

    // auto, man(2), force, ref(4), lock, hist | mode(2), locked, lol, src(2)
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 2'd0, 1'b0, 4'b0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R2 stays free
        {1'b1, 2'd0, 1'b0, 4'b0001, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1}, // R2 free->lock
        {1'b1, 2'd0, 1'b0, 4'b0001, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1}, // R3 locked sets
        {1'b1, 2'd0, 1'b0, 4'b0001, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 2'd1}, // R4 lol
        {1'b1, 2'd0, 1'b0, 4'b0001, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1}, // R4 recover
        {1'b1, 2'd0, 1'b0, 4'b0010, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1}, // R5 alternate
        {1'b1, 2'd0, 1'b0, 4'b0000, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2}, // R5 to hold
        {1'b1, 2'd0, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd3}, // R7 frozen
        {1'b1, 2'd0, 1'b0, 4'b0100, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1}, // R6 return
        {1'b1, 2'd0, 1'b0, 4'b0100, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1}, // R6 relock
        {1'b1, 2'd0, 1'b1, 4'b0100, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2}, // R11 force
        {1'b0, 2'd0, 1'b0, 4'b0100, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0}, // R11 man free
        {1'b0, 2'd1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1}, // R11 man lock
        {1'b0, 2'd1, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1}, // R3 manual
        {1'b0, 2'd3, 1'b0, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1}, // R11 code 3
        {1'b0, 2'd2, 1'b0, 4'b1111, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2}, // R11 man hold
        {1'b1, 2'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2}  // R5 no free
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        auto_en = 1'b1; man_mode = 2'd0; force_hold = 1'b0; ref_vld = '0;
        lock_det = 1'b0; hist_avail = 1'b0;
        loop_word = 24'd100; hist_word = 24'd200;
        do_reset();

        // R1 reset state
        check("R1 mode",   mode, 0);
        check("R1 locked", locked, 0);
        check("R1 lol",    lol, 0);
        check("R1 src",    freq_src, 0);
        check("R1 word",   freq_word, 0);
        check("R1 timer",  hold_time, 0);

        for (int i = 0; i < NV; i++) begin
            {auto_en, man_mode, force_hold, ref_vld, lock_det, hist_avail} = VEC[i][15:6];
            step();
            check($sformatf("vec%0d mode R5 R6 R11", i), mode, VEC[i][5:4]);
            check($sformatf("vec%0d locked R3", i), locked, VEC[i][3]);
            check($sformatf("vec%0d lol R4", i), lol, VEC[i][2]);
            check($sformatf("vec%0d src R7 R8", i), freq_src, VEC[i][1:0]);
        end

        // frequency words and timer
        do_reset();
        auto_en = 1'b1; force_hold = 1'b0; ref_vld = 4'b0001;
        lock_det = 1'b1; hist_avail = 1'b0; loop_word = 24'h111;
        step();
        check("R8 loop word", freq_word, 24'h111);
        loop_word = 24'h222;
        step();
        check("R8 loop word follow", freq_word, 24'h222);
        ref_vld = '0; loop_word = 24'h333;
        step();
        check("R7 frozen on entry", freq_word, 24'h222);
        check("R9 zero on entry", hold_time, 0);
        loop_word = 24'h444;
        step();
        check("R7 frozen stays", freq_word, 24'h222);
        check("R9 counts", hold_time, 1);
        hist_avail = 1'b1;
        step();
        check("R7 history word", freq_word, 24'd200);
        for (int k = 0; k < 5; k++) step();
        check("R9 count 7", hold_time, 7);
        ref_vld = 4'b0001;
        step();
        check("R6 back to lock", mode, 1);
        check("R9 retained after exit", hold_time, 7);
        step();
        check("R9 retained later", hold_time, 7);
        ref_vld = '0;
        step();
        check("R9 restart on re-entry", hold_time, 0);
        for (int k = 0; k < 300; k++) step();
        check("R10 saturated", hold_time, 255);
        auto_en = 1'b0; man_mode = 2'd0;
        step();
        check("R2 free src", freq_src, 0);
        check("R2 free word", freq_word, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule